// File: doc/BRIEF.md
# Tapped-delay-line fine-time decoder

This block turns the raw state of a tapped delay line into a fine time measurement. The start edge travels along a chain of delay elements. On every rising edge of the stop clock the state of all taps is taken as one snapshot, where a set tap means the start edge has already passed that element. The snapshot goes through two register stages in series. A three-stage pipeline then counts the set taps, rounds the count to the nearest group of four taps, and scales that group index by a per-step delay in picoseconds.

Inside a group of four, the taps do not switch in a linear order and may switch out of order. Because of this the decoder does not look for a single transition point. It counts every set tap across the whole vector, so isolated bubbles only move the count by the number of misplaced bits. The block reports results no finer than one group step. Results are produced on every clock. An arming input qualifies which results are marked valid. Two flags report a snapshot with no taps set and a snapshot that ran off the end of the line.

Top module: `tdc_fine_decoder`

## Requirements
- R1: While `rst_n` is low, every output reads zero and both capture stages hold zero, whatever `taps_i` carries.
- R2: `count_o` equals the number of set bits in the snapshot, whatever their positions, including out-of-order bits and bubbles.
- R3: `bin_o` equals (`count_o` + 2) / 4 with integer division, so a half group rounds up. Examples: count 1 gives 0, count 2 gives 1, count 6 gives 2.
- R4: `time_o` equals `bin_o` multiplied by the step register value in force at the edge that produces the result. `time_o` is `BIN_W + STEP_W` bits wide, so full scale cannot wrap.
- R5: The step register resets to `STEP_DEF` (53 ps by default). It loads `step_i` on a rising edge where `step_we_i` is 1 and otherwise holds its value.
- R6: A snapshot sampled at rising edge k shows up on the outputs right after rising edge k+4: two capture stages, then three decode stages.
- R7: `nohit_o` is 1 exactly when the snapshot has no set tap.
- R8: `ovf_o` is 1 exactly when every tap of the snapshot is set, which means the start edge ran past the last element.
- R9: `valid_o` is 1 with a result exactly when `arm_i` was 1 at the edge that sampled that snapshot. The count, bin, time and flags are produced either way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stop clock; snapshots are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| taps_i | input | NTAPS | Raw delay-line tap states |
| arm_i | input | 1 | Marks the snapshot sampled at this edge as belonging to an armed start |
| step_we_i | input | 1 | Loads the step register from `step_i` |
| step_i | input | STEP_W | New per-group step delay in picoseconds |
| count_o | output | clog2(NTAPS+1) | Number of set taps |
| bin_o | output | clog2(NTAPS/4+1) | Nearest group index |
| time_o | output | BIN_W+STEP_W | Fine time in picoseconds |
| valid_o | output | 1 | Result belongs to an armed snapshot |
| nohit_o | output | 1 | Snapshot had no set tap |
| ovf_o | output | 1 | Snapshot had every tap set |

## Verification
The bench builds the block with 32 taps, a 10-bit step register and the 53 ps default. With only 32 taps, a random 32-bit word covers the whole snapshot, and a full thermometer sweep from zero to all-ones takes only a few dozen cycles. The 10-bit step lets the bench load the largest step value and then drive an all-ones snapshot, which exercises the full-scale product in `time_o`. Counts of 1, 2, 5 and 6 fall within the sweep and the single-bit patterns, so the rounding boundaries are checked directly.

// File: rtl/tdcf_pkg.sv
package tdcf_pkg;

  // Occupancy class of a snapshot, decided in the summing stage.
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_PART = 2'd1,
    HIT_FULL = 2'd2
  } hit_e;

  // Number of taps in one reported step.
  localparam int unsigned GRP_TAPS = 4;

endpackage

// File: rtl/tdcf_capture.sv
module tdcf_capture #(
  parameter int NTAPS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAPS-1:0] taps_i,
  input  logic             arm_i,
  output logic [NTAPS-1:0] snap_o,
  output logic             arm_o
);

  logic [NTAPS-1:0] s1_q, s1_d, s2_q, s2_d;
  logic             a1_q, a1_d, a2_q, a2_d;

  always_comb begin
    s1_d = taps_i;
    s2_d = s1_q;
    a1_d = arm_i;
    a2_d = a1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      a1_q <= 1'b0;
      a2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      a1_q <= a1_d;
      a2_q <= a2_d;
    end
  end

  assign snap_o = s2_q;
  assign arm_o  = a2_q;

  AST_ARM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |-> $past(arm_i, 2)); // R9

endmodule

// File: rtl/tdcf_popsum.sv
module tdcf_popsum
  import tdcf_pkg::*;
#(
  parameter int NTAPS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTAPS-1:0]           snap_i,
  input  logic                       arm_i,
  output logic [$clog2(NTAPS+1)-1:0] cnt_o,
  output hit_e                       hit_o,
  output logic                       arm_o
);

  localparam int NGRP  = NTAPS / GRP_TAPS;
  localparam int CNT_W = $clog2(NTAPS+1);
  localparam int GCW   = $clog2(GRP_TAPS+1);

  // Stage D1: per-group population counts
  logic [GCW-1:0] grp_d [NGRP];
  logic [GCW-1:0] grp_q [NGRP];
  logic           arm1_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      grp_d[g] = '0;
      for (int b = 0; b < GRP_TAPS; b++) begin
        grp_d[g] = grp_d[g] + GCW'(snap_i[g*GRP_TAPS + b]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q[g] <= '0;
      else        grp_q[g] <= grp_d[g];
    end
  end

  // Stage D2: total and occupancy class
  logic [CNT_W-1:0] sum_d, cnt_q;
  hit_e             hit_d, hit_q;
  logic             arm2_q;

  always_comb begin
    sum_d = '0;
    for (int g = 0; g < NGRP; g++) begin
      sum_d = sum_d + CNT_W'(grp_q[g]);
    end
    if (sum_d == '0)                 hit_d = HIT_NONE;
    else if (sum_d == CNT_W'(NTAPS)) hit_d = HIT_FULL;
    else                             hit_d = HIT_PART;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm1_q <= 1'b0;
      arm2_q <= 1'b0;
      cnt_q  <= '0;
      hit_q  <= HIT_NONE;
    end else begin
      arm1_q <= arm_i;
      arm2_q <= arm1_q;
      cnt_q  <= sum_d;
      hit_q  <= hit_d;
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = hit_q;
  assign arm_o = arm2_q;

  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o != 2'd3); // R7

endmodule

// File: rtl/tdcf_scale.sv
module tdcf_scale
  import tdcf_pkg::*;
#(
  parameter int NTAPS    = 64,
  parameter int STEP_W   = 16,
  parameter int STEP_DEF = 53
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [$clog2(NTAPS+1)-1:0]                    cnt_i,
  input  hit_e                                          hit_i,
  input  logic                                          arm_i,
  input  logic                                          step_we_i,
  input  logic [STEP_W-1:0]                             step_i,
  output logic [$clog2(NTAPS+1)-1:0]                    count_o,
  output logic [$clog2(NTAPS/GRP_TAPS+1)-1:0]           bin_o,
  output logic [$clog2(NTAPS/GRP_TAPS+1)+STEP_W-1:0]    time_o,
  output logic                                          valid_o,
  output logic                                          nohit_o,
  output logic                                          ovf_o
);

  localparam int NGRP   = NTAPS / GRP_TAPS;
  localparam int CNT_W  = $clog2(NTAPS+1);
  localparam int BIN_W  = $clog2(NGRP+1);
  localparam int TIME_W = BIN_W + STEP_W;

  // Step register with explicit load enable
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;

  always_comb begin
    step_en = step_we_i;
    step_d  = step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= STEP_W'(STEP_DEF);
    else if (step_en) step_q <= step_d;
  end

  // Stage D3: rounding and scaling
  logic [CNT_W:0]    rnd;
  logic [BIN_W-1:0]  bin_d, bin_q;
  logic [TIME_W-1:0] time_d, time_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              val_q, none_q, full_q;

  always_comb begin
    rnd    = {1'b0, cnt_i} + (CNT_W+1)'(GRP_TAPS/2);
    bin_d  = BIN_W'(rnd / (CNT_W+1)'(GRP_TAPS));
    time_d = TIME_W'(bin_d) * TIME_W'(step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bin_q  <= '0;
      time_q <= '0;
      val_q  <= 1'b0;
      none_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_i;
      bin_q  <= bin_d;
      time_q <= time_d;
      val_q  <= arm_i;
      none_q <= (hit_i == HIT_NONE);
      full_q <= (hit_i == HIT_FULL);
    end
  end

  assign count_o = cnt_q;
  assign bin_o   = bin_q;
  assign time_o  = time_q;
  assign valid_o = val_q;
  assign nohit_o = none_q;
  assign ovf_o   = full_q;

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_we_i |=> $stable(step_q)); // R5
  AST_TIME_ZERO_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_o == '0) |-> (time_o == '0)); // R4
  AST_BIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bin_o <= BIN_W'(NGRP)); // R3

endmodule

// File: rtl/tdc_fine_decoder.sv
module tdc_fine_decoder
  import tdcf_pkg::*;
#(
  parameter int NTAPS    = 64,
  parameter int STEP_W   = 16,
  parameter int STEP_DEF = 53
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [NTAPS-1:0]                            taps_i,
  input  logic                                        arm_i,
  input  logic                                        step_we_i,
  input  logic [STEP_W-1:0]                           step_i,
  output logic [$clog2(NTAPS+1)-1:0]                  count_o,
  output logic [$clog2(NTAPS/4+1)-1:0]                bin_o,
  output logic [$clog2(NTAPS/4+1)+STEP_W-1:0]         time_o,
  output logic                                        valid_o,
  output logic                                        nohit_o,
  output logic                                        ovf_o
);

  localparam int NGRP  = NTAPS / GRP_TAPS;
  localparam int CNT_W = $clog2(NTAPS+1);
  localparam int BIN_W = $clog2(NGRP+1);

  if ((NTAPS % GRP_TAPS) != 0 || NTAPS < GRP_TAPS) begin : g_bad_taps
    $error("NTAPS must be a non-zero multiple of the group size");
  end

  logic [NTAPS-1:0] snap;
  logic             arm_cap, arm_sum;
  logic [CNT_W-1:0] cnt_sum;
  hit_e             hit_sum;

  tdcf_capture #(.NTAPS(NTAPS)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .taps_i (taps_i),
    .arm_i  (arm_i),
    .snap_o (snap),
    .arm_o  (arm_cap)
  );

  tdcf_popsum #(.NTAPS(NTAPS)) u_popsum (
    .clk    (clk),
    .rst_n  (rst_n),
    .snap_i (snap),
    .arm_i  (arm_cap),
    .cnt_o  (cnt_sum),
    .hit_o  (hit_sum),
    .arm_o  (arm_sum)
  );

  tdcf_scale #(
    .NTAPS    (NTAPS),
    .STEP_W   (STEP_W),
    .STEP_DEF (STEP_DEF)
  ) u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_sum),
    .hit_i     (hit_sum),
    .arm_i     (arm_sum),
    .step_we_i (step_we_i),
    .step_i    (step_i),
    .count_o   (count_o),
    .bin_o     (bin_o),
    .time_o    (time_o),
    .valid_o   (valid_o),
    .nohit_o   (nohit_o),
    .ovf_o     (ovf_o)
  );

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(NTAPS)); // R2
  AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    nohit_o |-> (count_o == '0 && bin_o == '0 && time_o == '0)); // R7
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (count_o == CNT_W'(NTAPS) && bin_o == BIN_W'(NGRP))); // R8
  AST_VALID_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(arm_i, 5)); // R9

endmodule

// File: tb/tdc_fine_decoder_tb.sv
module tdc_fine_decoder_tb;

  localparam int NT = 32;
  localparam int SW = 10;
  localparam int SD = 53;
  localparam int CW = $clog2(NT+1);
  localparam int BW = $clog2(NT/4+1);
  localparam int TW = BW + SW;
  localparam int NG = NT / 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NT-1:0] taps_i;
  logic          arm_i;
  logic          step_we_i;
  logic [SW-1:0] step_i;
  logic [CW-1:0] count_o;
  logic [BW-1:0] bin_o;
  logic [TW-1:0] time_o;
  logic          valid_o, nohit_o, ovf_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  tdc_fine_decoder #(.NTAPS(NT), .STEP_W(SW), .STEP_DEF(SD)) u_dut (
    .clk(clk), .rst_n(rst_n), .taps_i(taps_i), .arm_i(arm_i),
    .step_we_i(step_we_i), .step_i(step_i), .count_o(count_o),
    .bin_o(bin_o), .time_o(time_o), .valid_o(valid_o),
    .nohit_o(nohit_o), .ovf_o(ovf_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: queue of sampled snapshots, step mirror
  logic [NT-1:0] q_taps[$];
  bit            q_arm[$];
  int            step_m;
  bit            exp_ok;
  int            e_cnt, e_bin, e_time;
  bit            e_val, e_none, e_full;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_taps.delete();
      q_arm.delete();
      step_m = SD;
      exp_ok = 0;
    end else begin
      q_taps.push_back(taps_i);
      q_arm.push_back(arm_i);
      if (q_taps.size() > 4) begin
        logic [NT-1:0] s;
        s      = q_taps.pop_front();
        e_val  = q_arm.pop_front();
        e_cnt  = $countones(s);
        e_bin  = (e_cnt + 2) / 4;
        e_time = e_bin * step_m;
        e_none = (e_cnt == 0);
        e_full = (e_cnt == NT);
        exp_ok = 1;
      end else begin
        exp_ok = 0;
      end
      if (step_we_i) step_m = int'(step_i);
    end
  end

  always @(negedge clk) begin
    if (rst_n && exp_ok && !done) begin
      chk("R2", "count", 64'(count_o), 64'(e_cnt));
      chk("R3", "bin",   64'(bin_o),   64'(e_bin));
      chk("R4", "time",  64'(time_o),  64'(e_time));
      chk("R9", "valid", 64'(valid_o), 64'(e_val));
      chk("R7", "nohit", 64'(nohit_o), 64'(e_none));
      chk("R8", "ovf",   64'(ovf_o),   64'(e_full));
    end
  end

  function automatic logic [NT-1:0] therm(input int n);
    logic [NT-1:0] o = '1;
    if (n <= 0) return '0;
    return o >> (NT - n);
  endfunction

  task automatic put(input logic [NT-1:0] t, input logic a);
    taps_i = t;
    arm_i  = a;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; taps_i = '1; arm_i = 1'b1; step_we_i = 1'b1; step_i = '1;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero
    chk("R1", "count", 64'(count_o), 0);
    chk("R1", "bin",   64'(bin_o),   0);
    chk("R1", "time",  64'(time_o),  0);
    chk("R1", "valid", 64'(valid_o), 0);
    chk("R1", "nohit", 64'(nohit_o), 0);
    chk("R1", "ovf",   64'(ovf_o),   0);
    taps_i = '0; arm_i = 1'b0; step_we_i = 1'b0; step_i = '0;
    rst_n = 1'b1;
    repeat (6) put('0, 1'b1);

    // R6: exact latency of a one-cycle full snapshot; R5 default step
    taps_i = '1;
    @(negedge clk);
    taps_i = '0;
    repeat (3) @(negedge clk);
    chk("R6", "ovf early", 64'(ovf_o), 0);
    @(negedge clk);
    chk("R6", "ovf on time", 64'(ovf_o), 1);
    chk("R5", "default step time", 64'(time_o), 64'(NG * SD));
    @(negedge clk);
    chk("R6", "ovf late", 64'(ovf_o), 0);

    // Thermometer sweep with mixed arming
    for (int n = 0; n <= NT; n++) put(therm(n), (n % 3) != 0);

    // Bubbles: hole below the edge and stray bit above it
    for (int n = 4; n <= NT - 4; n++) begin
      logic [NT-1:0] t;
      t = therm(n);
      t[n-2] = 1'b0;
      t[n+1] = 1'b1;
      put(t, 1'b1);
    end

    // Out-of-order bits inside groups
    put(32'h5555_5555, 1'b1);
    put(32'hA5A5_A5A5, 1'b1);
    put(32'h0F0F_0F0F, 1'b0);
    put(32'h8421_8421, 1'b1);

    // Rounding edges: one, two, five and six set bits
    for (int i = 0; i < NT; i++) put(NT'(1) << i, 1'b1);
    put(32'h0000_0003, 1'b1);
    put(32'h0000_001F, 1'b1);
    put(32'h0000_003F, 1'b1);

    // R5: load the largest step, then full scale
    step_we_i = 1'b1; step_i = '1;
    put('1, 1'b1);
    step_we_i = 1'b0; step_i = '0;
    put('1, 1'b1);
    repeat (4) put('0, 1'b0);
    chk("R4", "full-scale time", 64'(time_o), 64'(NG * ((1 << SW) - 1)));

    // Random snapshots, arming and step writes
    for (int k = 0; k < 400; k++) begin
      step_we_i = (($urandom % 16) == 0);
      step_i    = SW'($urandom);
      put(NT'($urandom), 1'($urandom));
    end
    step_we_i = 1'b0;
    repeat (6) put('0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule